// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Control Core

This block is the digital half of an 8-bit successive-approximation converter that is read over a three-wire serial link. An active-low chip select frames each transaction, and the serial clock is the only clock. While the transaction is idle the block watches the data input for a start bit. The two bits that follow are held as the channel-mux controls. The block then allows one clock for the mux to settle. After that it runs one binary-search step per clock, presenting a trial code to the resistor-ladder decoder and reading back a single comparator bit from the analog side.

Each decided bit goes onto the serial output on the clock that decides it, so the word leaves most significant bit first. Once the last bit is decided, a shift register one bit wider than the word plays the result back least significant bit first. The bit that ended the first stream is not sent twice. When the playback is done, the shift register runs dry and leaves the output low. The serial output is presented as a data bit plus an output-enable that a pad driver turns into a three-state pin. The final code and a one-clock end-of-conversion strobe are also brought out, so the surrounding logic can compare them against an ideal model.

Top module: `sarSerialCore`

## Requirements
- R1: While `csN` is low and no 1 has yet been sampled on `din` at a rising `clk` edge, zeros on `din` are ignored and `doutEn` stays low.
- R2: The first 1 sampled on `din` is the start bit. The two bits sampled on the next two edges are held on `muxSgl` and then `muxOdd` until chip select rises. With `muxSgl`=1, `muxOdd` picks channel 1 (1) or channel 0 (0) as a single-ended input. With `muxSgl`=0, `muxOdd`=0 selects channel 0 minus channel 1, and `muxOdd`=1 selects channel 1 minus channel 0.
- R3: After the edge that samples the second mux bit, `doutEn` is high and `dout` is 0 for exactly one clock (the settling clock), and `din` is ignored. After the following edge, `trialCode` equals 8'h80.
- R4: In each of the eight decision clocks, for bit position i counted down from 7 to 0, `trialCode` holds the bits already decided above i, has bit i set, and has all lower bits clear. Bit i is kept when `cmpHi` is 1 (input at or above the trial level) and cleared otherwise.
- R5: After each decision edge, `dout` shows the bit just decided, so the eight bits leave MSB first.
- R6: `eocStrobe` is high for exactly the one clock that follows the bit-0 decision edge. From then on, `resultCode` holds the full code.
- R7: On the seven edges after the bit-0 decision, `dout` shows bits 1 through 7 in that order. Bit 0 is not repeated.
- R8: After the playback, `dout` stays 0 with `doutEn` high, and further clocks and `din` values change neither `dout` nor `resultCode`, until `csN` rises.
- R9: `csN` high asynchronously returns the block to idle, even in the middle of a conversion. It drops `doutEn`, clears `trialCode` to 0, and keeps a 1 on `din` from being taken as a start bit.
- R10: In differential mode, when the negative leg is above the positive leg, the result is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| csN | input | 1 | Active-low chip select; high is an asynchronous return to idle |
| din | input | 1 | Serial input carrying the start bit and the two mux bits |
| cmpHi | input | 1 | Comparator result: 1 when the selected input is at or above the trial level |
| muxSgl | output | 1 | Held mux control: 1 single-ended, 0 differential |
| muxOdd | output | 1 | Held mux control: channel or polarity choice |
| trialCode | output | 8 | Trial level for the ladder decoder during conversion, otherwise 0 |
| dout | output | 1 | Serial output data bit |
| doutEn | output | 1 | Output enable for the three-state serial pin |
| resultCode | output | 8 | Converted code |
| eocStrobe | output | 1 | One-clock end-of-conversion pulse |

## Verification
The embedded properties take two things for granted about the inputs. `cmpHi` is taken to be a settled function of the present `trialCode` and the mux selection before each rising edge, and `csN` is taken to be the only reset. The bench keeps to both. It changes `din` and `csN` one nanosecond after a rising edge, and it computes `cmpHi` combinationally from its own analog model of the selected channel against the trial code. The sweeps cover every single-ended level on both channels and a grid of differential pairs in both polarities, including negative differences. They also cover chip-select aborts at several decision steps, each followed by a clean conversion.

// File: rtl/sarPkg.sv
package sarPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SGL,
    ST_ODD,
    ST_SETTLE,
    ST_CONV,
    ST_REPLAY
  } ctlState_t;

  typedef struct packed {
    logic clrSar;
    logic decide;
    logic load;
    logic shift;
  } dpStrobe_t;

endpackage

// File: rtl/sarCtl.sv
module sarCtl
  import sarPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             csN,
  input  logic             din,
  output dpStrobe_t        strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic             muxSgl,
  output logic             muxOdd,
  output logic             doutEn,
  output logic             eocStrobe
);

  ctlState_t state;
  logic      lastStep;

  assign lastStep = (state == ST_CONV) && (bitIdx == '0);

  always_ff @(posedge clk or posedge csN) begin
    if (csN) begin
      state     <= ST_IDLE;
      bitIdx    <= '0;
      muxSgl    <= 1'b0;
      muxOdd    <= 1'b0;
      eocStrobe <= 1'b0;
    end else begin
      eocStrobe <= lastStep;
      case (state)
        ST_IDLE:   if (din) state <= ST_SGL;
        ST_SGL:    begin muxSgl <= din; state <= ST_ODD; end
        ST_ODD:    begin muxOdd <= din; state <= ST_SETTLE; end
        ST_SETTLE: begin
          bitIdx <= IDX_W'(DATA_W - 1);
          state  <= ST_CONV;
        end
        ST_CONV: begin
          if (bitIdx == '0) state <= ST_REPLAY;
          else              bitIdx <= bitIdx - 1'b1;
        end
        ST_REPLAY: state <= ST_REPLAY;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.clrSar = (state == ST_SETTLE);
    strb.decide = (state == ST_CONV);
    strb.load   = lastStep;
    strb.shift  = (state == ST_REPLAY);
  end

  assign doutEn = (state == ST_SETTLE) || (state == ST_CONV) || (state == ST_REPLAY);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (csN)
    (state == ST_IDLE && !din) |=> (state == ST_IDLE));

  // R6
  eoc_single_chk: assert property (@(posedge clk) disable iff (csN)
    eocStrobe |=> !eocStrobe);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (csN)
    $onehot0({strb.clrSar, strb.decide, strb.shift}));

  // R2
  mux_hold_chk: assert property (@(posedge clk) disable iff (csN)
    (state == ST_CONV || state == ST_REPLAY) |=> ($stable(muxSgl) && $stable(muxOdd)));

endmodule

// File: rtl/sarDp.sv
module sarDp
  import sarPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              csN,
  input  dpStrobe_t         strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              cmpHi,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] resultCode,
  output logic              doutBit
);

  logic [DATA_W-1:0] sar;
  logic [DATA_W:0]   shreg;
  logic              liveBit;
  logic [DATA_W-1:0] stepMask;

  assign stepMask = {{(DATA_W-1){1'b0}}, 1'b1} << bitIdx;

  always_ff @(posedge clk or posedge csN) begin
    if (csN) begin
      sar     <= '0;
      shreg   <= '0;
      liveBit <= 1'b0;
    end else begin
      if (strb.clrSar) begin
        sar     <= '0;
        liveBit <= 1'b0;
      end
      if (strb.decide) begin
        sar[bitIdx] <= cmpHi;
        liveBit     <= cmpHi;
      end
      if (strb.load)  shreg <= {1'b0, sar[DATA_W-1:1], cmpHi};
      if (strb.shift) shreg <= shreg >> 1;
    end
  end

  assign trialCode  = strb.decide ? (sar | stepMask) : '0;
  assign resultCode = sar;
  assign doutBit    = strb.shift ? shreg[0] : liveBit;

  // R5
  live_bit_chk: assert property (@(posedge clk) disable iff (csN)
    strb.decide |=> (liveBit == $past(cmpHi)));

  // R7
  replay_shift_chk: assert property (@(posedge clk) disable iff (csN)
    strb.shift |=> (shreg == ($past(shreg) >> 1)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (csN)
    strb.shift |=> $stable(sar));

endmodule

// File: rtl/sarSerialCore.sv
module sarSerialCore
  import sarPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              csN,
  input  logic              din,
  input  logic              cmpHi,
  output logic              muxSgl,
  output logic              muxOdd,
  output logic [DATA_W-1:0] trialCode,
  output logic              dout,
  output logic              doutEn,
  output logic [DATA_W-1:0] resultCode,
  output logic              eocStrobe
);

  localparam int IDX_W = $clog2(DATA_W);

  dpStrobe_t        strb;
  logic [IDX_W-1:0] bitIdx;
  logic             doutBit;

  sarCtl #(.DATA_W(DATA_W)) uCtl (
    .clk       (clk),
    .csN       (csN),
    .din       (din),
    .strb      (strb),
    .bitIdx    (bitIdx),
    .muxSgl    (muxSgl),
    .muxOdd    (muxOdd),
    .doutEn    (doutEn),
    .eocStrobe (eocStrobe)
  );

  sarDp #(.DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .csN        (csN),
    .strb       (strb),
    .bitIdx     (bitIdx),
    .cmpHi      (cmpHi),
    .trialCode  (trialCode),
    .resultCode (resultCode),
    .doutBit    (doutBit)
  );

  assign dout = doutEn & doutBit;

endmodule

// File: tb/sim_sarSerialCore.sv
module sim_sarSerialCore;

  logic       clk = 1'b0;
  logic       csN = 1'b1;
  logic       din = 1'b0;
  logic       cmpHi;
  logic       muxSgl, muxOdd, dout, doutEn, eocStrobe;
  logic [7:0] trialCode, resultCode;

  int v0 = 0;
  int v1 = 0;
  int vin;
  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  sarSerialCore u0 (
    .clk(clk), .csN(csN), .din(din), .cmpHi(cmpHi),
    .muxSgl(muxSgl), .muxOdd(muxOdd), .trialCode(trialCode),
    .dout(dout), .doutEn(doutEn), .resultCode(resultCode), .eocStrobe(eocStrobe)
  );

  // analog side: mux, ladder and comparator
  always_comb begin
    if (muxSgl) vin = muxOdd ? v1 : v0;
    else        vin = muxOdd ? (v1 - v0) : (v0 - v1);
    cmpHi = (vin >= int'(trialCode));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic d);
    din = d;
    @(posedge clk);
    #1;
  endtask

  function automatic int idealCode(input bit sgl, input bit odd, input int a0, input int a1);
    int x;
    if (sgl) x = odd ? a1 : a0;
    else     x = odd ? (a1 - a0) : (a0 - a1);
    return (x < 0) ? 0 : x;
  endfunction

  task automatic convert(input bit sgl, input bit odd, input int a0, input int a1, input int lz);
    int expCode;
    logic [7:0] msb, lsb;
    bit negDiff;
    v0 = a0; v1 = a1;
    expCode = idealCode(sgl, odd, a0, a1);
    negDiff = !sgl && ((odd ? (a1 - a0) : (a0 - a1)) < 0);
    csN = 1'b0;
    for (int k = 0; k < lz; k++) begin
      tick(1'b0);
      chk(!doutEn, "R1 idle", int'(doutEn), 0);
    end
    tick(1'b1);
    chk(!doutEn, "R1 start", int'(doutEn), 0);
    tick(sgl);
    tick(odd);
    chk(muxSgl == sgl && muxOdd == odd, "R2 mux", int'({muxSgl, muxOdd}), int'({sgl, odd}));
    chk(doutEn && !dout, "R3 settle", int'({doutEn, dout}), 2);
    tick(1'b1);
    chk(trialCode == 8'h80, "R3 first trial", int'(trialCode), 8'h80);
    for (int i = 7; i >= 0; i--) begin
      int expTrial;
      expTrial = ((expCode >> (i + 1)) << (i + 1)) | (1 << i);
      chk(int'(trialCode) == expTrial, "R4 trial", int'(trialCode), expTrial);
      tick(i[0]);
      msb[i] = dout;
    end
    chk(int'(msb) == expCode, "R5 msb stream", int'(msb), expCode);
    chk(eocStrobe && int'(resultCode) == expCode, "R6 eoc", int'({eocStrobe, resultCode}), 256 + expCode);
    lsb = '0;
    lsb[0] = msb[0];
    for (int k = 1; k < 8; k++) begin
      tick(k[1]);
      lsb[k] = dout;
      if (k == 1) chk(!eocStrobe, "R6 pulse", int'(eocStrobe), 0);
    end
    chk(lsb[7:1] == 7'(expCode >> 1), "R7 lsb stream", int'(lsb), expCode);
    if (negDiff) chk(int'(resultCode) == 0, "R10 negative diff", int'(resultCode), 0);
    for (int k = 0; k < 3; k++) begin
      tick(1'b1);
      chk(doutEn && !dout && int'(resultCode) == expCode, "R8 tail",
          int'({doutEn, dout, resultCode}), 512 + expCode);
    end
    csN = 1'b1;
    #1;
    chk(!doutEn && trialCode == 8'h00, "R9 release", int'({doutEn, trialCode}), 0);
    tick(1'b0);
  endtask

  task automatic abortRun(input int stepsDone);
    v0 = 200; v1 = 0;
    csN = 1'b0;
    tick(1'b1); tick(1'b1); tick(1'b0); tick(1'b0);
    for (int i = 0; i < stepsDone; i++) tick(1'b0);
    csN = 1'b1;
    #1;
    chk(!doutEn && trialCode == 8'h00 && !eocStrobe, "R9 abort", int'({doutEn, trialCode}), 0);
    tick(1'b1);
    tick(1'b1);
    chk(!doutEn, "R9 cs high start", int'(doutEn), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #1;
    tick(1'b1);
    tick(1'b1);
    chk(!doutEn && !eocStrobe && trialCode == 8'h00, "R9 reset state",
        int'({doutEn, eocStrobe, trialCode}), 0);
    for (int v = 0; v < 256; v++) convert(1'b1, 1'b0, v, 255 - v, v % 3);
    for (int v = 0; v < 256; v++) convert(1'b1, 1'b1, 37, v, 0);
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 23) begin
        convert(1'b0, 1'b0, a, b, 1);
        convert(1'b0, 1'b1, a, b, 0);
      end
    for (int s = 0; s < 8; s += 3) begin
      abortRun(s);
      convert(1'b1, 1'b0, 129, 0, 2);
    end
    convert(1'b0, 1'b0, 0, 255, 0);
    convert(1'b0, 1'b1, 255, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule